// File: doc/BRIEF.md
# Variable-Length Instruction Framer and Address Generator

This block accepts a stream of instruction bytes, one byte per handshake. It cuts the stream into instructions of 2, 4 or 6 bytes and names each instruction's format. It pulls out the register numbers, the immediate or length byte, and the base and displacement pairs. For each storage operand it forms a 24-bit effective address. To do this it reads base and index values from a 16-entry general register file through three combinational read ports.

The result leaves as one registered record under a valid/ready handshake. While the consumer stalls, the block keeps collecting the bytes of the next instruction, up to one complete instruction. It does not execute instructions, fetch operands or raise exceptions.

Top module: `insn_framer`

## Requirements
- R1: Bits 7:6 of the first byte set the length: 00 gives 2 bytes, 01 or 10 gives 4, and 11 gives 6. `out_len` reports this byte count.
- R2: `out_fmt` is coded RR=0, RX=1, RS=2, SI=3, SS=4, S=5. Prefix 00 is RR, 01 is RX and 11 is SS. With prefix 10 the format depends on the opcode: 0xB2 is S, 0x80–0x8F and 0x98–0x9F are RS, and every other value is SI.
- R3: For RR, RX and RS, `out_r1` is the high nibble and `out_r2` the low nibble of byte 1. `out_op` is {byte0, byte1} for S and {0x00, byte0} otherwise.
- R4: For SI and SS, `out_imm` is byte 1, which holds the immediate value or the length code.
- R5: Slot A takes its base from byte 2 bits 7:4 and its 12-bit displacement from the rest of bytes 2–3. `out_ea_a` = displacement + base value, plus the index value (`out_r2`) for RX only. Slot B (SS only) is built the same way from bytes 4–5 and gives `out_ea_b`.
- R6: A base or index number of 0 adds zero to the address, whatever register 0 holds.
- R7: Only bits 23:0 of the register values are used, and the sum wraps modulo 2^24.
- R8: Fields that the format does not define read zero: r1/r2 outside RR/RX/RS, imm outside SI/SS, all of slot A for RR, and all of slot B outside SS.
- R9: While `out_valid` is high and `out_ready` is low, every output field stays unchanged.
- R10: While an output waits, the block still takes the bytes of the next instruction. Once that instruction is complete, `in_ready` drops until the waiting output is accepted. No byte is lost, and the order of instructions is kept.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte, first byte of each instruction first |
| in_ready | output | 1 | Block can take a byte |
| rf_addr_x | output | 4 | Register file read address, index |
| rf_data_x | input | 32 | Register file read data, index |
| rf_addr_a | output | 4 | Register file read address, slot A base |
| rf_data_a | input | 32 | Register file read data, slot A base |
| rf_addr_b | output | 4 | Register file read address, slot B base |
| rf_data_b | input | 32 | Register file read data, slot B base |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer accepts the record |
| out_fmt | output | 3 | Format code |
| out_len | output | 3 | Instruction length in bytes |
| out_op | output | 16 | Opcode |
| out_r1 | output | 4 | First register field |
| out_r2 | output | 4 | Second register / index / third register field |
| out_imm | output | 8 | Immediate or length byte |
| out_base_a | output | 4 | Slot A base register number |
| out_disp_a | output | 12 | Slot A displacement |
| out_base_b | output | 4 | Slot B base register number |
| out_disp_b | output | 12 | Slot B displacement |
| out_ea_a | output | 24 | Slot A effective address |
| out_ea_b | output | 24 | Slot B effective address |

## Verification
Suppose the byte counter drifts or the length decode is wrong. The current instruction then comes out with the wrong format or fields, and every later instruction is misframed, so one bad count spoils the rest of the stream at the very next output record. If stale buffer bytes leak into fields the format does not define, they show up as nonzero values in fields that should read zero, in the same record. If the hold logic is broken, the fields change in the first cycle after a stalled record. If the buffer limit is wrong, `in_ready` stays high while a complete instruction is waiting, and this is visible in that same cycle.

// File: rtl/insn_framer.sv
module insn_framer #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          in_ready,
  output logic [3:0]    rf_addr_x,
  input  logic [DW-1:0] rf_data_x,
  output logic [3:0]    rf_addr_a,
  input  logic [DW-1:0] rf_data_a,
  output logic [3:0]    rf_addr_b,
  input  logic [DW-1:0] rf_data_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_fmt,
  output logic [2:0]    out_len,
  output logic [15:0]   out_op,
  output logic [3:0]    out_r1,
  output logic [3:0]    out_r2,
  output logic [7:0]    out_imm,
  output logic [3:0]    out_base_a,
  output logic [11:0]   out_disp_a,
  output logic [3:0]    out_base_b,
  output logic [11:0]   out_disp_b,
  output logic [AW-1:0] out_ea_a,
  output logic [AW-1:0] out_ea_b
);
  localparam int NB = 6;
  localparam int CW = $clog2(NB + 1);
  localparam logic [2:0] F_RR = 3'd0, F_RX = 3'd1, F_RS = 3'd2,
                         F_SI = 3'd3, F_SS = 3'd4, F_S  = 3'd5;

  logic [7:0]    bytes_q [NB];
  logic [CW-1:0] cnt_q;
  logic [2:0]    len_w, fmt_w;
  logic          complete, xfer, in_fire;
  logic          has_reg, has_imm, has_a, has_b;
  logic [AW-1:0] bval_a, bval_b, xval, ea_a_w, ea_b_w;

  wire [7:0] op0 = bytes_q[0];

  always_comb begin
    case (op0[7:6])
      2'b00:   len_w = 3'd2;
      2'b11:   len_w = 3'd6;
      default: len_w = 3'd4;
    endcase
  end

  always_comb begin
    case (op0[7:6])
      2'b00: fmt_w = F_RR;
      2'b01: fmt_w = F_RX;
      2'b11: fmt_w = F_SS;
      default:
        if (op0 == 8'hB2)                                fmt_w = F_S;
        else if (op0[5:4] == 2'b00 || op0[5:3] == 3'b011) fmt_w = F_RS;
        else                                             fmt_w = F_SI;
    endcase
  end

  assign complete = ({{(CW-3){1'b0}}, len_w} == cnt_q);
  assign xfer     = complete && (!out_valid || out_ready);
  assign in_ready = !complete || xfer;
  assign in_fire  = in_valid && in_ready;

  assign has_reg = (fmt_w == F_RR) || (fmt_w == F_RX) || (fmt_w == F_RS);
  assign has_imm = (fmt_w == F_SI) || (fmt_w == F_SS);
  assign has_a   = (fmt_w != F_RR);
  assign has_b   = (fmt_w == F_SS);

  assign rf_addr_x = bytes_q[1][3:0];
  assign rf_addr_a = bytes_q[2][7:4];
  assign rf_addr_b = bytes_q[4][7:4];

  assign xval   = (fmt_w == F_RX && rf_addr_x != 4'd0) ? rf_data_x[AW-1:0] : '0;
  assign bval_a = (rf_addr_a != 4'd0) ? rf_data_a[AW-1:0] : '0;
  assign bval_b = (rf_addr_b != 4'd0) ? rf_data_b[AW-1:0] : '0;
  assign ea_a_w = {{(AW-12){1'b0}}, bytes_q[2][3:0], bytes_q[3]} + bval_a + xval;
  assign ea_b_w = {{(AW-12){1'b0}}, bytes_q[4][3:0], bytes_q[5]} + bval_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NB; i++) bytes_q[i] <= '0;
    end else if (xfer) begin
      cnt_q <= in_fire ? CW'(1) : '0;
      if (in_fire) bytes_q[0] <= in_byte;
    end else if (in_fire) begin
      bytes_q[cnt_q] <= in_byte;
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fmt    <= '0;
      out_len    <= '0;
      out_op     <= '0;
      out_r1     <= '0;
      out_r2     <= '0;
      out_imm    <= '0;
      out_base_a <= '0;
      out_disp_a <= '0;
      out_base_b <= '0;
      out_disp_b <= '0;
      out_ea_a   <= '0;
      out_ea_b   <= '0;
    end else if (xfer) begin
      out_valid  <= 1'b1;
      out_fmt    <= fmt_w;
      out_len    <= len_w;
      out_op     <= (fmt_w == F_S) ? {op0, bytes_q[1]} : {8'h00, op0};
      out_r1     <= has_reg ? bytes_q[1][7:4] : 4'd0;
      out_r2     <= has_reg ? bytes_q[1][3:0] : 4'd0;
      out_imm    <= has_imm ? bytes_q[1] : 8'd0;
      out_base_a <= has_a ? rf_addr_a : 4'd0;
      out_disp_a <= has_a ? {bytes_q[2][3:0], bytes_q[3]} : 12'd0;
      out_ea_a   <= has_a ? ea_a_w : '0;
      out_base_b <= has_b ? rf_addr_b : 4'd0;
      out_disp_b <= has_b ? {bytes_q[4][3:0], bytes_q[5]} : 12'd0;
      out_ea_b   <= has_b ? ea_b_w : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

module insn_framer_chk #(
  parameter int AW = 24,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2:0]    out_fmt,
  input logic [2:0]    out_len,
  input logic [15:0]   out_op,
  input logic [7:0]    out_imm,
  input logic [3:0]    out_base_a,
  input logic [11:0]   out_disp_a,
  input logic [AW-1:0] out_ea_a,
  input logic [AW-1:0] out_ea_b,
  input logic [CW-1:0] cnt_q
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_fmt, out_len, out_op, out_imm, out_base_a, out_disp_a, out_ea_a, out_ea_b}));

  a_r1_len_matches_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_len == 3'd2) == (out_fmt == 3'd0)) &&
                  ((out_len == 3'd6) == (out_fmt == 3'd4)));

  a_r8_rr_no_address: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt == 3'd0 |-> out_ea_a == '0 && out_ea_b == '0 && out_base_a == 4'd0);

  a_r6_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt inside {3'd2, 3'd3, 3'd5} && out_base_a == 4'd0
      |-> out_ea_a == {{(AW-12){1'b0}}, out_disp_a});

  a_r10_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(6));
endmodule

bind insn_framer insn_framer_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_fmt(out_fmt), .out_len(out_len), .out_op(out_op), .out_imm(out_imm),
  .out_base_a(out_base_a), .out_disp_a(out_disp_a), .out_ea_a(out_ea_a),
  .out_ea_b(out_ea_b), .cnt_q(cnt_q)
);

// File: tb/tb_insn_framer.sv
module tb_insn_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic [3:0]  rf_addr_x, rf_addr_a, rf_addr_b;
  logic [31:0] rf_data_x, rf_data_a, rf_data_b;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_fmt, out_len;
  logic [15:0] out_op;
  logic [3:0]  out_r1, out_r2, out_base_a, out_base_b;
  logic [7:0]  out_imm;
  logic [11:0] out_disp_a, out_disp_b;
  logic [23:0] out_ea_a, out_ea_b;

  always #5 clk = ~clk;

  logic [31:0] regs [16];
  assign rf_data_x = regs[rf_addr_x];
  assign rf_data_a = regs[rf_addr_a];
  assign rf_data_b = regs[rf_addr_b];

  insn_framer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .rf_addr_x(rf_addr_x), .rf_data_x(rf_data_x), .rf_addr_a(rf_addr_a), .rf_data_a(rf_data_a),
    .rf_addr_b(rf_addr_b), .rf_data_b(rf_data_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_fmt(out_fmt), .out_len(out_len), .out_op(out_op), .out_r1(out_r1), .out_r2(out_r2),
    .out_imm(out_imm), .out_base_a(out_base_a), .out_disp_a(out_disp_a),
    .out_base_b(out_base_b), .out_disp_b(out_disp_b), .out_ea_a(out_ea_a), .out_ea_b(out_ea_b)
  );

  typedef struct packed {
    logic [2:0]  fmt;
    logic [2:0]  len;
    logic [15:0] op;
    logic [3:0]  r1, r2;
    logic [7:0]  imm;
    logic [3:0]  ba;
    logic [11:0] da;
    logic [3:0]  bb;
    logic [11:0] db;
    logic [23:0] ea_a, ea_b;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    checks = 0, fails = 0;
  int    rmode = 0;
  bit    finished = 0;

  function automatic logic [23:0] rv(input logic [3:0] i);
    return (i == 4'd0) ? 24'h0 : regs[i][23:0];
  endfunction

  function automatic exp_t model(input logic [47:0] w);
    exp_t e;
    logic [7:0] b0, b1;
    b0 = w[47:40];
    b1 = w[39:32];
    e = '0;
    case (b0[7:6])
      2'b00: e.fmt = 3'd0;
      2'b01: e.fmt = 3'd1;
      2'b11: e.fmt = 3'd4;
      default: begin
        if (b0 == 8'hB2) e.fmt = 3'd5;
        else if ((b0 >= 8'h80 && b0 <= 8'h8F) || (b0 >= 8'h98 && b0 <= 8'h9F)) e.fmt = 3'd2;
        else e.fmt = 3'd3;
      end
    endcase
    e.len = (e.fmt == 3'd0) ? 3'd2 : (e.fmt == 3'd4) ? 3'd6 : 3'd4;
    e.op  = (e.fmt == 3'd5) ? {b0, b1} : {8'h00, b0};
    if (e.fmt <= 3'd2) begin
      e.r1 = b1[7:4];
      e.r2 = b1[3:0];
    end
    if (e.fmt == 3'd3 || e.fmt == 3'd4) e.imm = b1;
    if (e.fmt != 3'd0) begin
      e.ba   = w[31:28];
      e.da   = w[27:16];
      e.ea_a = 24'(e.da) + rv(e.ba) + ((e.fmt == 3'd1) ? rv(e.r2) : 24'h0);
    end
    if (e.fmt == 3'd4) begin
      e.bb   = w[15:12];
      e.db   = w[11:0];
      e.ea_b = 24'(e.db) + rv(e.bb);
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic send(input logic [47:0] w, input string tag);
    exp_t e;
    e = model(w);
    q.push_back(e);
    tq.push_back(tag);
    for (int i = 0; i < int'(e.len); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = w[47 - 8*i -: 8];
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = ~out_ready;
        default: out_ready = 1'b0;
      endcase
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected output", 64'(out_op), 64'h0);
        end else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = tq.pop_front();
          check(out_len == e.len, {"R1 length ", t}, 64'(out_len), 64'(e.len));
          check(out_fmt == e.fmt, {"R2 format ", t}, 64'(out_fmt), 64'(e.fmt));
          check({out_op, out_r1, out_r2} == {e.op, e.r1, e.r2}, {"R3 op/regs ", t},
                64'({out_op, out_r1, out_r2}), 64'({e.op, e.r1, e.r2}));
          check(out_imm == e.imm, {"R4 imm ", t}, 64'(out_imm), 64'(e.imm));
          check({out_base_a, out_disp_a, out_base_b, out_disp_b} == {e.ba, e.da, e.bb, e.db},
                {"R8 base/disp ", t}, 64'({out_base_a, out_disp_a, out_base_b, out_disp_b}),
                64'({e.ba, e.da, e.bb, e.db}));
          check({out_ea_a, out_ea_b} == {e.ea_a, e.ea_b}, {"R5 address ", t},
                64'({out_ea_a, out_ea_b}), 64'({e.ea_a, e.ea_b}));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'(q.size()), 64'h0);
    finish_run();
  end

  task automatic run_set(input string sfx);
    send(48'h1837_0000_0000, {"RR ", sfx});
    send(48'h5B35_C024_0000, {"RX base+index ", sfx});
    send(48'h5A30_C024_0000, {"R6 RX index zero ", sfx});
    send(48'h5810_0100_0000, {"R6 RX base and index zero ", sfx});
    send(48'h9868_C024_0000, {"RS 98 ", sfx});
    send(48'h8712_C001_0000, {"RS 87 ", sfx});
    send(48'h92F3_C231_0000, {"SI 92 ", sfx});
    send(48'hA011_C001_0000, {"SI A0 ", sfx});
    send(48'hD202_C106_C735, {"SS ", sfx});
    send(48'hF833_0010_0020, {"R6 SS zero bases ", sfx});
    send(48'hB220_D010_0000, {"R7 S wrap ", sfx});
    send(48'h411D_DFFF_0000, {"R7 RX double wrap ", sfx});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0000_0000;
    regs[0]  = 32'h00AB_CDEF;
    regs[5]  = 32'h1100_2000;
    regs[12] = 32'hAA00_5400;
    regs[13] = 32'h77FF_FFF0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R11 reset out_valid", 64'(out_valid), 64'h0);
    check(in_ready == 1'b1, "R11 reset in_ready", 64'(in_ready), 64'h1);

    rmode = 0;
    run_set("streaming");
    drain();

    rmode = 1;
    run_set("R9 alternating ready");
    drain();

    rmode = 2;
    send(48'h5B35_C024_0000, "R10 held RX");
    send(48'h1A45_0000_0000, "R10 queued RR");
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R9 stalled output valid", 64'(out_valid), 64'h1);
    check(in_ready == 1'b0, "R10 in_ready low when full", 64'(in_ready), 64'h0);
    check(out_ea_a == q[0].ea_a, "R9 held address", 64'(out_ea_a), 64'(q[0].ea_a));
    repeat (3) @(negedge clk);
    #1;
    check(out_fmt == q[0].fmt && out_ea_a == q[0].ea_a, "R9 still held",
          64'({out_fmt, out_ea_a}), 64'({q[0].fmt, q[0].ea_a}));
    check(in_ready == 1'b0, "R10 still blocked", 64'(in_ready), 64'h0);
    rmode = 0;
    drain();
    check(q.size() == 0, "R10 all outputs delivered", 64'(q.size()), 64'h0);

    finish_run();
  end
endmodule